// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block holds the exception state of a 16-bit processor whose physical addresses are 23 bits wide. When an external exception request arrives, or a trap instruction is issued, it saves the resume PC, the status word and the current code bank. It clears the interrupt enables in the status word and fetches a new PC from a vector table in page 0. While that read is outstanding it holds `busy` so the core stalls instruction issue. The response loads the core's PC and asks for a refetch.

The block also executes the single-register system instructions. These are return-from-interrupt, trap, and get/set access to the code-bank register, the saved PC, the saved status word, a scratch register for handlers, the last exception number and the vector base. It reads operands through a register-file read port and returns results through a register-file write port. PC and status updates reach the core on dedicated load strobes. The code-bank register keeps the live bank in its low byte and the bank saved at exception entry in its high byte.

Top module: `exc_ctrl`

## Requirements
- R1: After reset, `busy`, `mem_req`, `pc_load`, `sr_load`, `rf_we` and `refetch` are low, and `pch_o` is 0.
- R2: On acceptance of an exception, the saved PC becomes `cur_pc - 2` (16-bit wrap) and the saved status becomes `cur_sr`. getepc and getesr return these values.
- R3: On acceptance, the saved bank takes the current bank value and `pch_o` reads 0 from the next cycle on.
- R4: In the acceptance cycle, `sr_load` is high and `sr_next` equals `cur_sr` with bit 0 (interrupt 0 enable) and bit 1 (interrupt 1 enable) cleared and every other bit unchanged.
- R5: From the cycle after acceptance, `mem_req` is high with `mem_addr = (vbr + 2*number) mod 65536`, held stable until `mem_ack`. In the ack cycle, `pc_load` is high, `pc_next = mem_rdata` and `refetch` pulses.
- R6: `busy` is high from the cycle after acceptance through the ack cycle. While busy, new exception requests and issued system instructions have no effect.
- R7: Sub-opcode 1 (trap) starts an exception whose number is the register field, zero-extended. If an exception request and an issued instruction coincide, the request is taken and the instruction is dropped.
- R8: Sub-opcode 0 (return) writes the scratch register to the named register, except when that is r14 or r15. It loads PC from the saved PC and the status word from the saved status, restores the current bank from the saved bank and pulses `refetch`.
- R9: Sub-opcode 4 returns {1'b0, saved bank, 1'b0, current bank}. Sub-opcode 5 loads the saved bank from operand bits 14:8 and the current bank from bits 6:0, and pulses `refetch`.
- R10: Even sub-opcodes 6, 8, 10, 12 and 14 write the saved PC, saved status, scratch, exception number and vector base to the named register. The odd sub-opcodes that follow each load the same register from the named register's value.
- R11: A get instruction (even sub-opcode 4 to 14) naming r14 pulses `refetch`; a get naming any other register does not.
- R12: Sub-opcodes 2 and 3 (push, pop) cause no register write, no load, no refetch and no change of the special registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| exc_req | input | 1 | External exception request |
| exc_num | input | NUM_W | Number of the requested exception |
| sys_valid | input | 1 | A system instruction is issued |
| sys_op | input | 4 | System sub-opcode |
| sys_reg | input | IDX_W | Register field of the instruction |
| cur_pc | input | 16 | Core PC at exception acceptance |
| cur_sr | input | 16 | Core status word |
| rf_raddr | output | IDX_W | Register-file read index |
| rf_rdata | input | 16 | Register-file read data |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | IDX_W | Register-file write index |
| rf_wdata | output | 16 | Register-file write data |
| mem_req | output | 1 | Vector read request |
| mem_addr | output | 16 | Page-0 vector address |
| mem_ack | input | 1 | Vector read response valid |
| mem_rdata | input | 16 | Vector read data |
| pc_load | output | 1 | Load core PC |
| pc_next | output | 16 | New PC value |
| sr_load | output | 1 | Load core status word |
| sr_next | output | 16 | New status value |
| pch_o | output | PCH_W | Current code bank |
| refetch | output | 1 | Discard prefetch and refetch |
| busy | output | 1 | Stall instruction issue |

## Verification
The vector path is driven with a vector base near the top of the 16-bit space so that the computed address wraps, and with responses that arrive in the first fetch cycle or several cycles later. This separates a correct wrap and hold from a stale or unheld address. Traps, requests and a request that coincides with an issued instruction show which exception number is captured and which source has priority. The get and set instructions are issued to r14, to r15 and to ordinary registers, and operands carry bits 7 and 15 set, which tests the refetch rule, the write suppression on return and the 7-bit bank truncation.

// File: rtl/exc_pkg.sv
package exc_pkg;
   localparam int WORD_W = 16;

   typedef enum logic [3:0] {
      OP_RETI, OP_TRAP, OP_PUSH, OP_POP,
      OP_GETPCH, OP_SETPCH, OP_GETEPC, OP_SETEPC,
      OP_GETESR, OP_SETESR, OP_GETUER, OP_SETUER,
      OP_GETENUM, OP_SETENUM, OP_GETVBR, OP_SETVBR
   } sysop_e;

   typedef enum logic [2:0] {
      SR_NONE, SR_PCH, SR_EPC, SR_ESR, SR_UER, SR_ENUM, SR_VBR
   } sreg_e;

   typedef enum logic {ST_IDLE, ST_FETCH} seq_e;

   typedef struct packed {
      logic  take;
      logic  reti;
      logic  get;
      logic  set;
      sreg_e sel;
   } dec_t;

   // get/set pairs share sub-opcode bits 3:1
   function automatic sreg_e pair_sel(input logic [2:0] pair);
      case (pair)
         3'd2:    return SR_PCH;
         3'd3:    return SR_EPC;
         3'd4:    return SR_ESR;
         3'd5:    return SR_UER;
         3'd6:    return SR_ENUM;
         3'd7:    return SR_VBR;
         default: return SR_NONE;
      endcase
   endfunction
endpackage

// File: rtl/exc_decode.sv
module exc_decode
   import exc_pkg::*;
#(
   parameter int IDX_W  = 4,
   parameter int PC_IDX = 14,
   parameter int SR_IDX = 15
) (
   input  logic             sys_valid,
   input  logic [3:0]       sys_op,
   input  logic [IDX_W-1:0] sys_reg,
   input  logic             busy,
   input  logic             exc_req,
   output dec_t             dec,
   output logic             rf_we,
   output logic             refetch_req
);
   logic   issue;
   logic   dst_pc;
   logic   dst_sr;
   sysop_e op;

   assign op     = sysop_e'(sys_op);
   assign issue  = sys_valid & ~busy & ~exc_req;
   assign dst_pc = (sys_reg == IDX_W'(PC_IDX));
   assign dst_sr = (sys_reg == IDX_W'(SR_IDX));

   always_comb begin
      dec = '{take: 1'b0, reti: 1'b0, get: 1'b0, set: 1'b0, sel: SR_NONE};
      if (issue) begin
         case (op)
            OP_RETI: dec.reti = 1'b1;
            OP_TRAP: dec.take = 1'b1;
            OP_PUSH, OP_POP: dec.sel = SR_NONE;
            default: begin
               dec.get = ~sys_op[0];
               dec.set = sys_op[0];
               dec.sel = pair_sel(sys_op[3:1]);
            end
         endcase
      end
   end

   assign rf_we       = dec.get | (dec.reti & ~dst_pc & ~dst_sr);
   assign refetch_req = dec.reti
                      | (dec.set & (dec.sel == SR_PCH))
                      | (dec.get & dst_pc);
endmodule

// File: rtl/exc_sregs.sv
module exc_sregs
   import exc_pkg::*;
#(
   parameter int               PCH_W   = 7,
   parameter logic [WORD_W-1:0] VBR_RST = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              entry,
   input  logic [WORD_W-1:0] entry_pc,
   input  logic [WORD_W-1:0] entry_sr,
   input  logic [WORD_W-1:0] entry_num,
   input  logic              restore,
   input  logic              set_en,
   input  sreg_e             set_sel,
   input  logic [WORD_W-1:0] set_data,
   output logic [WORD_W-1:0] epc,
   output logic [WORD_W-1:0] esr,
   output logic [WORD_W-1:0] uer,
   output logic [WORD_W-1:0] enum_q,
   output logic [WORD_W-1:0] vbr,
   output logic [PCH_W-1:0]  pch_cur,
   output logic [PCH_W-1:0]  pch_sav
);
   localparam int SAV_LSB = WORD_W / 2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         epc     <= '0;
         esr     <= '0;
         uer     <= '0;
         enum_q  <= '0;
         vbr     <= VBR_RST;
         pch_cur <= '0;
         pch_sav <= '0;
      end else if (entry) begin
         epc     <= entry_pc - WORD_W'(2);
         esr     <= entry_sr;
         enum_q  <= entry_num;
         pch_sav <= pch_cur;
         pch_cur <= '0;
      end else if (restore) begin
         pch_cur <= pch_sav;
      end else if (set_en) begin
         case (set_sel)
            SR_PCH: begin
               pch_sav <= set_data[SAV_LSB +: PCH_W];
               pch_cur <= set_data[PCH_W-1:0];
            end
            SR_EPC:  epc    <= set_data;
            SR_ESR:  esr    <= set_data;
            SR_UER:  uer    <= set_data;
            SR_ENUM: enum_q <= set_data;
            SR_VBR:  vbr    <= set_data;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/exc_seq.sv
module exc_seq
   import exc_pkg::*;
#(
   parameter bit VEC_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WORD_W-1:0] vec_num,
   input  logic [WORD_W-1:0] vbr,
   input  logic              mem_ack,
   output logic              busy,
   output logic              mem_req,
   output logic [WORD_W-1:0] mem_addr,
   output logic              vec_done
);
   seq_e st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_IDLE;
      else begin
         case (st)
            ST_IDLE:  if (start)   st <= ST_FETCH;
            ST_FETCH: if (mem_ack) st <= ST_IDLE;
            default:  st <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (st == ST_FETCH);
   assign mem_req  = busy;
   assign vec_done = busy & mem_ack;

   generate
      if (VEC_REG) begin : g_addr_reg
         logic [WORD_W-1:0] addr_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     addr_q <= '0;
            else if (start) addr_q <= vbr + (vec_num << 1);
         end
         assign mem_addr = addr_q;
      end else begin : g_addr_comb
         assign mem_addr = vbr + (vec_num << 1);
      end
   endgenerate
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
   import exc_pkg::*;
#(
   parameter int               IDX_W       = 4,
   parameter int               NUM_W       = 8,
   parameter int               PCH_W       = 7,
   parameter int               INT_EN_BITS = 2,
   parameter int               PC_IDX      = 14,
   parameter int               SR_IDX      = 15,
   parameter bit               VEC_REG     = 1'b1,
   parameter logic [15:0]      VBR_RST     = 16'h0000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             exc_req,
   input  logic [NUM_W-1:0] exc_num,
   input  logic             sys_valid,
   input  logic [3:0]       sys_op,
   input  logic [IDX_W-1:0] sys_reg,
   input  logic [15:0]      cur_pc,
   input  logic [15:0]      cur_sr,
   output logic [IDX_W-1:0] rf_raddr,
   input  logic [15:0]      rf_rdata,
   output logic             rf_we,
   output logic [IDX_W-1:0] rf_waddr,
   output logic [15:0]      rf_wdata,
   output logic             mem_req,
   output logic [15:0]      mem_addr,
   input  logic             mem_ack,
   input  logic [15:0]      mem_rdata,
   output logic             pc_load,
   output logic [15:0]      pc_next,
   output logic             sr_load,
   output logic [15:0]      sr_next,
   output logic [PCH_W-1:0] pch_o,
   output logic             refetch,
   output logic             busy
);
   localparam int HALF_W = WORD_W / 2;

   generate
      if (PCH_W < 1 || PCH_W > HALF_W - 1) begin : g_bad_pch
         $error("PCH_W must fit below the top bit of a byte");
      end
      if (NUM_W < 1 || NUM_W > WORD_W) begin : g_bad_num
         $error("NUM_W must be 1..16");
      end
      if (IDX_W < 4) begin : g_bad_idx
         $error("IDX_W must address r15");
      end
      if (INT_EN_BITS < 0 || INT_EN_BITS > HALF_W) begin : g_bad_ie
         $error("INT_EN_BITS out of range");
      end
   endgenerate

   dec_t              dec;
   logic              dec_we;
   logic              dec_refetch;
   logic              accept;
   logic              vec_done;
   logic [WORD_W-1:0] entry_num;
   logic [WORD_W-1:0] vec_num;
   logic [WORD_W-1:0] epc, esr, uer, enum_q, vbr;
   logic [PCH_W-1:0]  pch_cur, pch_sav;
   logic [WORD_W-1:0] get_data;
   logic [WORD_W-1:0] ie_mask;

   exc_decode #(.IDX_W(IDX_W), .PC_IDX(PC_IDX), .SR_IDX(SR_IDX)) u_dec (
      .sys_valid  (sys_valid),
      .sys_op     (sys_op),
      .sys_reg    (sys_reg),
      .busy       (busy),
      .exc_req    (exc_req),
      .dec        (dec),
      .rf_we      (dec_we),
      .refetch_req(dec_refetch)
   );

   assign accept    = ~busy & (exc_req | dec.take);
   assign entry_num = exc_req ? WORD_W'(exc_num) : WORD_W'(sys_reg);
   assign vec_num   = VEC_REG ? entry_num : enum_q;

   exc_sregs #(.PCH_W(PCH_W), .VBR_RST(VBR_RST)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .entry    (accept),
      .entry_pc (cur_pc),
      .entry_sr (cur_sr),
      .entry_num(entry_num),
      .restore  (dec.reti),
      .set_en   (dec.set),
      .set_sel  (dec.sel),
      .set_data (rf_rdata),
      .epc      (epc),
      .esr      (esr),
      .uer      (uer),
      .enum_q   (enum_q),
      .vbr      (vbr),
      .pch_cur  (pch_cur),
      .pch_sav  (pch_sav)
   );

   exc_seq #(.VEC_REG(VEC_REG)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (accept),
      .vec_num (vec_num),
      .vbr     (vbr),
      .mem_ack (mem_ack),
      .busy    (busy),
      .mem_req (mem_req),
      .mem_addr(mem_addr),
      .vec_done(vec_done)
   );

   // interrupt-enable bits cleared on entry
   generate
      for (genvar b = 0; b < WORD_W; b++) begin : g_ie
         if (b < INT_EN_BITS) begin : g_on
            assign ie_mask[b] = 1'b1;
         end else begin : g_off
            assign ie_mask[b] = 1'b0;
         end
      end
   endgenerate

   always_comb begin
      case (dec.sel)
         SR_PCH:  get_data = {HALF_W'(pch_sav), HALF_W'(pch_cur)};
         SR_EPC:  get_data = epc;
         SR_ESR:  get_data = esr;
         SR_UER:  get_data = uer;
         SR_ENUM: get_data = enum_q;
         SR_VBR:  get_data = vbr;
         default: get_data = '0;
      endcase
   end

   assign rf_raddr = sys_reg;
   assign rf_waddr = sys_reg;
   assign rf_we    = dec_we;
   assign rf_wdata = dec.reti ? uer : get_data;

   assign sr_load  = accept | dec.reti;
   assign sr_next  = dec.reti ? esr : (cur_sr & ~ie_mask);
   assign pc_load  = vec_done | dec.reti;
   assign pc_next  = vec_done ? mem_rdata : epc;
   assign refetch  = vec_done | dec_refetch;
   assign pch_o    = pch_cur;
endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk #(
   parameter int IDX_W = 4,
   parameter int PCH_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             exc_req,
   input logic             sys_valid,
   input logic [3:0]       sys_op,
   input logic [IDX_W-1:0] sys_reg,
   input logic             busy,
   input logic             mem_req,
   input logic [15:0]      mem_addr,
   input logic             mem_ack,
   input logic             pc_load,
   input logic             sr_load,
   input logic             rf_we,
   input logic             refetch,
   input logic [PCH_W-1:0] pch_o
);
   logic issue;
   assign issue = sys_valid & ~busy & ~exc_req;

   // R3
   bank_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (pch_o == '0));

   // R5
   addr_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> $stable(mem_addr));

   // R5
   vec_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && mem_ack) |-> (pc_load && refetch));

   // R6
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !mem_ack) |=> busy);

   // R6
   busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (!rf_we && !sr_load));

   // R8
   reti_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && sys_op == 4'd0) |-> (pc_load && sr_load && refetch));

   // R11
   get_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && !sys_op[0] && sys_op[3:2] != 2'b00 && sys_reg == IDX_W'(14))
      |-> refetch);

   // R12
   pushpop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && sys_op[3:1] == 3'd1)
      |-> (!rf_we && !refetch && !sr_load && !pc_load));
endmodule

bind exc_ctrl exc_ctrl_chk #(.IDX_W(IDX_W), .PCH_W(PCH_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .exc_req  (exc_req),
   .sys_valid(sys_valid),
   .sys_op   (sys_op),
   .sys_reg  (sys_reg),
   .busy     (busy),
   .mem_req  (mem_req),
   .mem_addr (mem_addr),
   .mem_ack  (mem_ack),
   .pc_load  (pc_load),
   .sr_load  (sr_load),
   .rf_we    (rf_we),
   .refetch  (refetch),
   .pch_o    (pch_o)
);

// File: tb/sim_exc_ctrl.sv
module sim_exc_ctrl;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        exc_req = 1'b0;
   logic [7:0]  exc_num = '0;
   logic        sys_valid = 1'b0;
   logic [3:0]  sys_op = '0;
   logic [3:0]  sys_reg = '0;
   logic [15:0] cur_pc = '0, cur_sr = '0;
   logic [15:0] next_pc = '0, next_sr = '0;
   logic [3:0]  rf_raddr, rf_waddr;
   logic [15:0] rf_rdata, rf_wdata, mem_addr, pc_next, sr_next;
   logic        rf_we, mem_req, pc_load, sr_load, refetch, busy;
   logic        mem_ack = 1'b0;
   logic [15:0] mem_rdata = '0;
   logic [6:0]  pch_o;
   logic [15:0] rf_mem [16];

   int    checks = 0, errors = 0, cycles = 0;
   bit    done = 1'b0;
   string tag = "R1";

   always #(CLK_P/2) clk = ~clk;

   exc_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_num(exc_num),
      .sys_valid(sys_valid), .sys_op(sys_op), .sys_reg(sys_reg),
      .cur_pc(cur_pc), .cur_sr(cur_sr), .rf_raddr(rf_raddr),
      .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
      .rf_wdata(rf_wdata), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .pc_load(pc_load),
      .pc_next(pc_next), .sr_load(sr_load), .sr_next(sr_next),
      .pch_o(pch_o), .refetch(refetch), .busy(busy)
   );

   assign rf_rdata = rf_mem[rf_raddr];
   always @(posedge clk) if (rf_we) rf_mem[rf_waddr] <= rf_wdata;

   task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // reference model state
   bit         m_busy;
   logic [15:0] m_epc, m_esr, m_uer, m_enum, m_vbr;
   logic [6:0]  m_pc, m_ps;

   always @(negedge clk) begin
      bit          e_we, e_pcl, e_srl, e_ref, e_mreq;
      logic [15:0] e_wd, e_pcn, e_srn, e_ma, v;
      #(CLK_P/4);
      if (!rst_n) begin
         m_busy = 0; m_epc = 0; m_esr = 0; m_uer = 0; m_enum = 0;
         m_vbr = 0; m_pc = 0; m_ps = 0;
      end else begin
         e_we = 0; e_pcl = 0; e_srl = 0; e_ref = 0; e_mreq = 0;
         e_wd = 0; e_pcn = 0; e_srn = 0; e_ma = 0;
         v = rf_mem[sys_reg];
         chk("pch_o", {9'd0, pch_o}, {9'd0, m_pc});
         chk("busy", {15'd0, busy}, {15'd0, m_busy});
         if (m_busy) begin
            e_mreq = 1; e_ma = 16'(m_vbr + m_enum * 2);
            if (mem_ack) begin
               e_pcl = 1; e_pcn = mem_rdata; e_ref = 1; m_busy = 0;
            end
         end else if (exc_req || (sys_valid && sys_op == 4'd1)) begin
            e_srl = 1; e_srn = cur_sr & 16'hFFFC;
            m_epc = 16'(cur_pc - 16'd2); m_esr = cur_sr;
            m_enum = exc_req ? {8'd0, exc_num} : {12'd0, sys_reg};
            m_ps = m_pc; m_pc = 0; m_busy = 1;
         end else if (sys_valid) begin
            case (sys_op)
               4'd0: begin
                  e_pcl = 1; e_pcn = m_epc; e_srl = 1; e_srn = m_esr; e_ref = 1;
                  if (sys_reg < 4'd14) begin e_we = 1; e_wd = m_uer; end
                  m_pc = m_ps;
               end
               4'd4: begin e_we = 1; e_wd = {1'b0, m_ps, 1'b0, m_pc}; end
               4'd5: begin m_ps = v[14:8]; m_pc = v[6:0]; e_ref = 1; end
               4'd6: begin e_we = 1; e_wd = m_epc; end
               4'd7: m_epc = v;
               4'd8: begin e_we = 1; e_wd = m_esr; end
               4'd9: m_esr = v;
               4'd10: begin e_we = 1; e_wd = m_uer; end
               4'd11: m_uer = v;
               4'd12: begin e_we = 1; e_wd = m_enum; end
               4'd13: m_enum = v;
               4'd14: begin e_we = 1; e_wd = m_vbr; end
               4'd15: m_vbr = v;
               default: ;
            endcase
            if (sys_op >= 4'd4 && !sys_op[0] && sys_reg == 4'd14) e_ref = 1;
         end
         chk("mem_req", {15'd0, mem_req}, {15'd0, e_mreq});
         if (e_mreq) chk("mem_addr", mem_addr, e_ma);
         chk("pc_load", {15'd0, pc_load}, {15'd0, e_pcl});
         if (e_pcl) chk("pc_next", pc_next, e_pcn);
         chk("sr_load", {15'd0, sr_load}, {15'd0, e_srl});
         if (e_srl) chk("sr_next", sr_next, e_srn);
         chk("rf_we", {15'd0, rf_we}, {15'd0, e_we});
         if (e_we) begin
            chk("rf_wdata", rf_wdata, e_wd);
            chk("rf_waddr", {12'd0, rf_waddr}, {12'd0, sys_reg});
         end
         chk("refetch", {15'd0, refetch}, {15'd0, e_ref});
      end
   end

   task automatic cyc(input string t, input bit er, input logic [7:0] en,
                      input bit sv, input logic [3:0] op, input logic [3:0] rg,
                      input bit ack, input logic [15:0] rd);
      @(negedge clk);
      tag = t; exc_req = er; exc_num = en; sys_valid = sv; sys_op = op;
      sys_reg = rg; mem_ack = ack; mem_rdata = rd;
      cur_pc = next_pc; cur_sr = next_sr;
   endtask

   task automatic ins(input string t, input logic [3:0] op, input logic [3:0] rg);
      cyc(t, 0, 8'd0, 1, op, rg, 0, 16'd0);
   endtask

   task automatic idle(input string t);
      cyc(t, 0, 8'd0, 0, 4'd0, 4'd0, 0, 16'd0);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=<20000", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 16; i++) rf_mem[i] = 16'(i * 16'h0101);
      rf_mem[3] = 16'hFFF0;
      rf_mem[4] = 16'hAA95;
      rf_mem[7] = 16'h1234;
      rf_mem[11] = 16'h0F00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle("R1"); idle("R1");
      // R10 vector base set/get
      ins("R10", 4'd15, 4'd3); ins("R10", 4'd14, 4'd5); idle("R10");
      // R9 bank register, bits 15 and 7 dropped
      ins("R9", 4'd5, 4'd4); ins("R9", 4'd4, 4'd6); idle("R9");
      // R10 scratch register
      ins("R10", 4'd11, 4'd7); ins("R10", 4'd10, 4'd8);
      // R4 R5 R6: exception 9, address wraps, late ack, ignored inputs while busy
      next_pc = 16'h0100; next_sr = 16'h7F1F;
      cyc("R4", 1, 8'd9, 0, 4'd0, 4'd0, 0, 16'd0);
      cyc("R6", 0, 8'd0, 1, 4'd14, 4'd5, 0, 16'd0);
      cyc("R6", 1, 8'd3, 0, 4'd0, 4'd0, 0, 16'd0);
      cyc("R5", 0, 8'd0, 0, 4'd0, 4'd0, 1, 16'h4000);
      idle("R5");
      // R2 R3 saved state readback
      ins("R2", 4'd6, 4'd1); ins("R2", 4'd8, 4'd2); ins("R2", 4'd12, 4'd10);
      ins("R3", 4'd4, 4'd6);
      // R8 return
      ins("R8", 4'd0, 4'd9); idle("R8");
      // R7 trap with immediate ack, PC wrap on save
      next_pc = 16'h0001; next_sr = 16'hFFFF;
      ins("R7", 4'd1, 4'd5);
      cyc("R7", 0, 8'd0, 0, 4'd0, 4'd0, 1, 16'h0800);
      ins("R7", 4'd6, 4'd1); ins("R7", 4'd12, 4'd2);
      // R7 request beats a coinciding setvbr
      next_pc = 16'h0200;
      cyc("R7", 1, 8'h80, 1, 4'd15, 4'd11, 0, 16'd0);
      cyc("R7", 0, 8'd0, 0, 4'd0, 4'd0, 1, 16'h0900);
      ins("R7", 4'd14, 4'd12);
      // R12 push/pop
      ins("R12", 4'd2, 4'd3); ins("R12", 4'd3, 4'd4);
      ins("R12", 4'd14, 4'd5); ins("R12", 4'd4, 4'd6);
      // R11 get to PC vs other regs
      ins("R11", 4'd6, 4'd14); ins("R11", 4'd8, 4'd13); ins("R11", 4'd10, 4'd14);
      // R8 return naming PC and SR: no register write
      ins("R8", 4'd0, 4'd14); ins("R8", 4'd0, 4'd15);
      // R10 remaining set/get pairs
      ins("R10", 4'd7, 4'd4); ins("R10", 4'd9, 4'd3); ins("R10", 4'd13, 4'd7);
      ins("R10", 4'd6, 4'd1); ins("R10", 4'd8, 4'd2); ins("R10", 4'd12, 4'd10);
      idle("R10"); idle("R10");
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule